// File: doc/BRIEF.md
# Odd-Polynomial Residue Nonlinearity Corrector

This block sits after the backend of a two-stage converter whose first residue amplifier runs open loop. That amplifier compresses large residues with a cubic term. The backend word therefore carries a predictable odd-order distortion. The block undoes it digitally. Each valid sample code `x` is replaced by `x + p·x³ + 3p²·x⁵ + 12p³·x⁷`, where `p` is a single distortion coefficient. The amplifier error is thus handled in the digital domain and not in the analog chain.

The coefficient drifts with temperature, so an external estimator can write a new `p` at any time, even while samples are streaming. The three derived coefficients `p`, `3p²` and `12p³` are computed from `p` once, over a few cycles, into a staging set. The staging set is then copied into the active set in a single cycle. The per-sample path only forms the powers of `x` in a registered multiply chain, scales them by the active set, adds, and clamps the result to the output word.

Top module: `resid_poly_corrector`

## Requirements
- R1: Codes are signed two's complement with all bits but the sign as fraction: `inCode`/`outCode` have W-1 fraction bits and `loadP2` has CW-1 fraction bits. With `f = W-1`, `g = CW-1` and `>>>` an arithmetic (floor) shift:
  - Powers: `x2=(x*x)>>>f`, `x3=(x*x2)>>>f`, `x5=(x3*x2)>>>f`, `x7=(x5*x2)>>>f`.
  - Coefficients: `k1=p`, `k2=3*((p*p)>>>g)`, `k3=12*((((p*p)>>>g)*p)>>>g)`.
  - Result: `x + (k1*x3>>>g) + (k2*x5>>>g) + (k3*x7>>>g)`, then saturated as in R4.
- R2: A sample taken with `inValid` high on a rising edge appears with `outValid` high after the fifth following rising edge, for a latency of 6 register stages. Cycles with `inValid` low produce no output pulse. Back-to-back and gapped streams keep their order and count.
- R3: While `outValid` is low, `outCode` keeps the last value it produced.
- R4: A result above 2^(W-1)-1 is output as 2^(W-1)-1. A result below -2^(W-1) is output as -2^(W-1). Wrapping never occurs.
- R5: A coefficient taken with `loadValid` on rising edge L becomes active on edge L+3, provided no load comes on edges L+1 to L+3. A sample entering on edge L or later uses it. A sample entering on edge L-1 uses the previous set.
- R6: A load arriving before the previous load has become active cancels the previous one, which never takes effect; the most recent load wins.
- R7: Every output is computed from one coefficient set. During a stream with a load, samples before the switching point match the old set exactly, and samples after it match the new set exactly.
- R8: Synchronous active-high `rst` clears `outValid`, sets `outCode` to 0 and clears all coefficients to 0.
- R9: With a zero coefficient (after reset, or after loading 0), `outCode` equals `inCode` for every sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Sample strobe for `inCode` |
| inCode | input | W | Backend code, signed fraction |
| loadValid | input | 1 | Strobe to take a new coefficient |
| loadP2 | input | CW | Distortion coefficient, signed fraction |
| outValid | output | 1 | Corrected sample strobe |
| outCode | output | W | Corrected, saturated code |

## Verification
The hardest situation to reach from the ports is a coefficient swap that lands exactly between two adjacent samples of a continuous stream. A related case is a second load that arrives in the very cycle the first one would have committed. The bench drives the loads from inside the streaming loop, on chosen sample indices. This places the load edge relative to specific samples, including a second load three edges after the first. Each sample's expected value is then computed with the set the timing rules assign to it, so a leaked or mixed coefficient shows up as a wrong output code.

// File: rtl/corrPkg.sv
package corrPkg;

  // Strobes from the coefficient sequencer to the datapath.
  typedef struct packed {
    logic capture;   // take loadP2 into the held register
    logic doSquare;  // form p*p
    logic doCube;    // form 3p^2 and 12p^3 into the staging set
    logic commit;    // copy staging set into the active set
  } coefStrobe_t;

  // Register stages from inCode to outCode.
  localparam int unsigned PIPE_LATENCY = 6;

endpackage

// File: rtl/coefCtrl.sv
module coefCtrl
  import corrPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        loadValid,
  output coefStrobe_t strobe
);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SQUARE,
    ST_CUBE,
    ST_COMMIT
  } seqState_t;

  seqState_t state;

  // A fresh load always restarts the sequence (latest wins).
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else if (loadValid) begin
      state <= ST_SQUARE;
    end else begin
      case (state)
        ST_SQUARE: state <= ST_CUBE;
        ST_CUBE:   state <= ST_COMMIT;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.capture  = loadValid;
    strobe.doSquare = (state == ST_SQUARE) && !loadValid;
    strobe.doCube   = (state == ST_CUBE)   && !loadValid;
    strobe.commit   = (state == ST_COMMIT) && !loadValid;
  end

endmodule

// File: rtl/polyDatapath.sv
module polyDatapath
  import corrPkg::*;
#(
  parameter int W  = 12,
  parameter int CW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  coefStrobe_t          strobe,
  input  logic signed [CW-1:0] loadP2,
  input  logic                 inValid,
  input  logic signed [W-1:0]  inCode,
  output logic                 outValid,
  output logic signed [W-1:0]  outCode
);

  localparam int F     = W - 1;          // sample fraction bits
  localparam int CF    = CW - 1;         // coefficient fraction bits
  localparam int PW    = W + 1;          // power width (holds +1.0)
  localparam int KW    = CW + 5;         // coefficient width (holds 12.0)
  localparam int SW    = W + 6;          // accumulator width
  localparam int VSTG  = PIPE_LATENCY - 1;
  localparam logic signed [SW-1:0] SAT_HI = SW'((2 ** (W - 1)) - 1);
  localparam logic signed [SW-1:0] SAT_LO = SW'(-(2 ** (W - 1)));

  // ---------------- coefficient preparation ----------------
  logic signed [CW-1:0]     pHeld;
  logic signed [KW-1:0]     sqReg, c2Stage, c3Stage;
  logic signed [KW-1:0]     c1Act, c2Act, c3Act;
  logic signed [2*CW-1:0]   sqFull;
  logic signed [KW+CW-1:0]  cubeFull, cubeSh;

  assign sqFull   = pHeld * pHeld;
  assign cubeFull = (KW+CW)'(sqReg) * (KW+CW)'(pHeld);
  assign cubeSh   = cubeFull >>> CF;

  always_ff @(posedge clk) begin
    if (rst) begin
      pHeld   <= '0;
      sqReg   <= '0;
      c2Stage <= '0;
      c3Stage <= '0;
      c1Act   <= '0;
      c2Act   <= '0;
      c3Act   <= '0;
    end else begin
      if (strobe.capture)  pHeld <= loadP2;
      if (strobe.doSquare) sqReg <= KW'(sqFull >>> CF);
      if (strobe.doCube) begin
        c2Stage <= (sqReg <<< 1) + sqReg;
        c3Stage <= KW'((cubeSh <<< 3) + (cubeSh <<< 2));
      end
      if (strobe.commit) begin
        c1Act <= KW'(pHeld);
        c2Act <= c2Stage;
        c3Act <= c3Stage;
      end
    end
  end

  // ---------------- sample pipeline ----------------
  function automatic logic signed [PW-1:0] fracMul(
    input logic signed [PW-1:0] a,
    input logic signed [PW-1:0] b
  );
    logic signed [2*PW-1:0] prod;
    prod = a * b;
    return PW'(prod >>> F);
  endfunction

  function automatic logic signed [SW-1:0] coefMul(
    input logic signed [KW-1:0] k,
    input logic signed [PW-1:0] v
  );
    logic signed [KW+PW-1:0] prod;
    prod = (KW+PW)'(k) * (KW+PW)'(v);
    return SW'(prod >>> CF);
  endfunction

  logic [VSTG-1:0]       vPipe;
  logic signed [W-1:0]   xDly [VSTG];
  logic signed [PW-1:0]  sq1, sq2, sq3;
  logic signed [PW-1:0]  cub2, cub3, cub4;
  logic signed [PW-1:0]  pow5s3, pow5s4, pow7s4;
  logic signed [SW-1:0]  term1, term2, term3;
  logic signed [SW-1:0]  sumAll, satVal;

  // valid tag and raw sample travel through a shift chain
  always_ff @(posedge clk) begin
    if (rst) vPipe <= '0;
    else     vPipe <= {vPipe[VSTG-2:0], inValid};
  end

  always_ff @(posedge clk) xDly[0] <= inCode;

  for (genvar s = 1; s < VSTG; s++) begin : g_xDelay
    always_ff @(posedge clk) xDly[s] <= xDly[s-1];
  end

  always_ff @(posedge clk) begin
    // stage 1: x^2
    sq1    <= fracMul(PW'(inCode), PW'(inCode));
    // stage 2: x^3
    cub2   <= fracMul(PW'(xDly[0]), sq1);
    sq2    <= sq1;
    // stage 3: x^5
    pow5s3 <= fracMul(cub2, sq2);
    cub3   <= cub2;
    sq3    <= sq2;
    // stage 4: x^7
    pow7s4 <= fracMul(pow5s3, sq3);
    pow5s4 <= pow5s3;
    cub4   <= cub3;
    // stage 5: scale by the active coefficient set
    term1  <= coefMul(c1Act, cub4);
    term2  <= coefMul(c2Act, pow5s4);
    term3  <= coefMul(c3Act, pow7s4);
  end

  always_comb begin
    sumAll = SW'(xDly[VSTG-1]) + term1 + term2 + term3;
    if (sumAll > SAT_HI)      satVal = SAT_HI;
    else if (sumAll < SAT_LO) satVal = SAT_LO;
    else                      satVal = sumAll;
  end

  // stage 6: saturated output, held while no sample arrives
  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outCode  <= '0;
    end else begin
      outValid <= vPipe[VSTG-1];
      if (vPipe[VSTG-1]) outCode <= W'(satVal);
    end
  end

endmodule

// File: rtl/resid_poly_corrector.sv
module resid_poly_corrector
  import corrPkg::*;
#(
  parameter int W  = 12,
  parameter int CW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic signed [W-1:0]  inCode,
  input  logic                 loadValid,
  input  logic signed [CW-1:0] loadP2,
  output logic                 outValid,
  output logic signed [W-1:0]  outCode
);

  coefStrobe_t strobe;

  coefCtrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .loadValid (loadValid),
    .strobe    (strobe)
  );

  polyDatapath #(.W(W), .CW(CW)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .loadP2   (loadP2),
    .inValid  (inValid),
    .inCode   (inCode),
    .outValid (outValid),
    .outCode  (outCode)
  );

endmodule

// File: rtl/corrChecker.sv
module corrChecker
  import corrPkg::*;
#(
  parameter int W = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                inValid,
  input logic                loadValid,
  input logic                outValid,
  input logic signed [W-1:0] outCode,
  input coefStrobe_t         strobe
);

  logic [3:0] sinceRst;

  always_ff @(posedge clk) begin
    if (rst)                 sinceRst <= '0;
    else if (sinceRst != 4'd15) sinceRst <= sinceRst + 4'd1;
  end

  // R2: output strobe follows input strobe by the fixed latency
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 4'd6) |-> (outValid == $past(inValid, 6)));

  // R3: code holds while no sample is presented
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 4'd1) && !outValid |-> $stable(outCode));

  // R5: an undisturbed load reaches the commit step three edges later
  assert_commit_timing_R5: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 4'd3) && $past(loadValid, 3) && !$past(loadValid, 2)
      && !$past(loadValid, 1) && !loadValid |-> strobe.commit);

  // R6: a load is never accompanied by another sequencing step
  assert_one_step_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe));

  // R6: a commit is never issued on the edge right after a load
  assert_no_early_commit_R6: assert property (@(posedge clk) disable iff (rst)
    loadValid |=> !strobe.commit);

endmodule

bind resid_poly_corrector corrChecker #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .loadValid (loadValid),
  .outValid  (outValid),
  .outCode   (outCode),
  .strobe    (strobe)
);

// File: tb/resid_poly_corrector_bench.sv
module resid_poly_corrector_bench;

  localparam int W  = 12;
  localparam int CW = 12;
  localparam int F  = W - 1;
  localparam int CF = CW - 1;
  localparam longint HI = (64'sd1 <<< (W - 1)) - 1;
  localparam longint LO = -(64'sd1 <<< (W - 1));

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 inValid = 1'b0;
  logic signed [W-1:0]  inCode = '0;
  logic                 loadValid = 1'b0;
  logic signed [CW-1:0] loadP2 = '0;
  logic                 outValid;
  logic signed [W-1:0]  outCode;

  int     checks = 0;
  int     failures = 0;
  bit     done = 1'b0;
  longint pCur = 0;
  logic [15:0] lfsr = 16'hACE1;
  longint gotQ[$];

  always #5 clk = ~clk;

  resid_poly_corrector #(.W(W), .CW(CW)) u_resid_poly_corrector (
    .clk(clk), .rst(rst), .inValid(inValid), .inCode(inCode),
    .loadValid(loadValid), .loadP2(loadP2),
    .outValid(outValid), .outCode(outCode)
  );

  always @(negedge clk) if (!rst && outValid) gotQ.push_back(longint'(outCode));

  function automatic longint model(input longint x, input longint p);
    longint sq, k1, k2, k3, x2, x3, x5, x7, s;
    sq = (p * p) >>> CF;
    k1 = p;
    k2 = 3 * sq;
    k3 = 12 * ((sq * p) >>> CF);
    x2 = (x * x) >>> F;
    x3 = (x * x2) >>> F;
    x5 = (x3 * x2) >>> F;
    x7 = (x5 * x2) >>> F;
    s = x + ((k1 * x3) >>> CF) + ((k2 * x5) >>> CF) + ((k3 * x7) >>> CF);
    if (s > HI) s = HI;
    if (s < LO) s = LO;
    return s;
  endfunction

  function automatic longint nextX();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return longint'($signed(lfsr[W-1:0]));
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Stream n cycles; optional loads at cycle indices la/lb (-1 = none).
  // gapEvery>0 drops inValid on every gapEvery-th cycle. useFix forces x.
  task automatic streamRun(input int n, input int la, input longint pa,
                           input int lb, input longint pb, input int gapEvery,
                           input bit useFix, input longint xFix, input string tag);
    longint expQ[$];
    longint x, pUse;
    bit v;
    bit aLives;
    gotQ.delete();
    aLives = (la >= 0) && !((lb >= 0) && (lb - la <= 3));
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      v = !(gapEvery > 0 && (i % gapEvery) == gapEvery - 1);
      x = useFix ? xFix : nextX();
      inValid   = v;
      inCode    = W'(x);
      loadValid = (i == la) || (i == lb);
      loadP2    = CW'((i == lb) ? pb : pa);
      if (lb >= 0 && i >= lb)      pUse = pb;
      else if (aLives && i >= la)  pUse = pa;
      else                         pUse = pCur;
      if (v) expQ.push_back(model(x, pUse));
    end
    @(negedge clk);
    inValid = 1'b0;
    loadValid = 1'b0;
    repeat (10) @(negedge clk);
    if (lb >= 0) pCur = pb; else if (la >= 0) pCur = pa;
    check(gotQ.size() == expQ.size(), {tag, " R2 count"}, gotQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < gotQ.size(); i++)
      check(gotQ[i] == expQ[i], tag, gotQ[i], expQ[i]);
  endtask

  task automatic loadCoef(input longint p);
    @(negedge clk);
    loadValid = 1'b1;
    loadP2 = CW'(p);
    @(negedge clk);
    loadValid = 1'b0;
    repeat (6) @(negedge clk);
    pCur = p;
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R8 outValid in reset", outValid, 0);
    check(outCode == 0, "R8 outCode in reset", outCode, 0);
    rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R8 outValid after reset", outValid, 0);
  endtask

  task automatic testIdentity();
    // R9: zero coefficient after reset passes codes through
    streamRun(24, -1, 0, -1, 0, 0, 1'b0, 0, "R9 identity after reset");
    loadCoef(0);
    streamRun(8, -1, 0, -1, 0, 0, 1'b1, -2048, "R9 identity loaded zero");
  endtask

  task automatic testLatency();
    int seen;
    gotQ.delete();
    @(negedge clk);
    inValid = 1'b1;
    inCode = W'(1000);
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      seen = outValid;
      check(seen == ((k == 6) ? 1 : 0), $sformatf("R2 latency edge %0d", k), seen, (k == 6));
    end
    check(gotQ.size() == 1, "R2 single pulse", gotQ.size(), 1);
  endtask

  task automatic testPoly();
    loadCoef(300);
    streamRun(30, -1, 0, -1, 0, 0, 1'b0, 0, "R1 p=300");
    loadCoef(-700);
    streamRun(30, -1, 0, -1, 0, 3, 1'b0, 0, "R1 p=-700 gapped");
    loadCoef(1500);
    streamRun(30, -1, 0, -1, 0, 0, 1'b0, 0, "R1 p=1500");
  endtask

  task automatic testHold();
    longint last;
    loadCoef(900);
    streamRun(6, -1, 0, -1, 0, 0, 1'b1, 1900, "R1 hold setup");
    last = gotQ[gotQ.size() - 1];
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(longint'(outCode) == last, "R3 hold while idle", outCode, last);
    end
  endtask

  task automatic testSat();
    loadCoef(2047);
    streamRun(3, -1, 0, -1, 0, 0, 1'b1, 2047, "R4 sat model hi");
    check(gotQ.size() > 0 && gotQ[0] == HI, "R4 clamp high", gotQ.size() > 0 ? gotQ[0] : 0, HI);
    streamRun(3, -1, 0, -1, 0, 0, 1'b1, -2048, "R4 sat model lo");
    check(gotQ.size() > 0 && gotQ[0] == LO, "R4 clamp low", gotQ.size() > 0 ? gotQ[0] : 0, LO);
  endtask

  task automatic testCommitEdge();
    loadCoef(400);
    // sample on edge L-1 uses old set, sample on edge L uses new
    streamRun(6, 1, -1200, -1, 0, 0, 1'b1, 1800, "R5 commit edge");
    check(gotQ.size() == 6 && gotQ[0] != gotQ[1], "R5 switch visible", gotQ.size() == 6 ? gotQ[1] : 0, model(1800, -1200));
  endtask

  task automatic testRestart();
    loadCoef(0);
    // second load three edges after the first hits the commit cycle
    streamRun(30, 5, 1800, 8, -900, 0, 1'b0, 0, "R6 restart at commit");
    loadCoef(0);
    streamRun(20, 4, 1800, 5, 600, 0, 1'b0, 0, "R6 restart back to back");
  endtask

  task automatic testAtomic();
    loadCoef(-500);
    streamRun(40, 20, 1300, -1, 0, 0, 1'b0, 0, "R7 swap mid stream");
    streamRun(40, 11, -1600, -1, 0, 2, 1'b0, 0, "R7 swap gapped stream");
  endtask

  initial begin
    testReset();
    testIdentity();
    testLatency();
    testPoly();
    testHold();
    testSat();
    testCommitEdge();
    testRestart();
    testAtomic();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule